// File: doc/BRIEF.md
# Serial Two-Channel PCM Input Receiver

This block turns a two-channel serial PCM stream into parallel samples. Three asynchronous inputs carry the stream: a bit clock, a word clock that marks which channel is on the line, and a data line. The block runs on a faster system clock. It synchronises the three inputs, finds each rising edge of the bit clock, and takes one data bit at every such edge. For every frame it produces one 16-bit two's-complement sample per channel.

Three static mode inputs set the framing. The slot-size input selects a 24-bit or a 32-bit slot per channel. The bit-order input selects whether the first valid bit is the MSB or the LSB. The placement input chooses the front half or the rear half of a 32-bit slot. Every bit outside the 16-bit valid window is thrown away.

A frame is complete once the channel-2 slot has ended. The block then loads both channel outputs together and raises a one-cycle strobe. The outputs hold their values until the next strobe.

Top module: `serial_pcm_rx`

## Requirements
- R1: While `rst` is high at a clock edge, `ch1_out`, `ch2_out` and `frame_valid` are all zero after that edge.
- R2: A data bit is taken only on a detected rising edge of `bck`. The value of `lrck` taken at the same edge assigns the bit to a channel: 1 means channel 1, 0 means channel 2.
- R3: With `slot32` = 0 (24-bit slot), the valid bits are the bits at slot indices 8 to 23, counting from 0 at the first bit of the slot. This holds whatever the value of `front_half`.
- R4: With `slot32` = 1 (32-bit slot), the valid bits are at indices 0 to 15 when `front_half` = 1, and at indices 16 to 31 when `front_half` = 0.
- R5: With `msb_first` = 1, the first valid bit is sample bit 15 and the following bits run down to bit 0. With `msb_first` = 0, the first valid bit is sample bit 0 and the following bits run up to bit 15.
- R6: Bits outside the valid window have no effect on either output.
- R7: `frame_valid` is a single-cycle pulse. It is issued once per frame, after the channel-2 slot ends, which is seen at the first `bck` rise that has `lrck` = 1. `ch1_out` and `ch2_out` change only in the cycle that the pulse is high.
- R8: After reset, a slot counts as complete only if the block saw its start at an `lrck` change. A frame is reported only after a complete channel-1 slot, so a partial slot at start-up never produces a pulse.
- R9: The slot bit index restarts at 0 on the first `bck` rise after each change of `lrck`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, faster than the bit clock |
| rst | input | 1 | Synchronous active-high reset |
| bck | input | 1 | Serial bit clock (asynchronous) |
| lrck | input | 1 | Word clock: 1 = channel 1 slot, 0 = channel 2 slot |
| sdat | input | 1 | Serial data line |
| slot32 | input | 1 | 1 = 32-bit slots, 0 = 24-bit slots |
| msb_first | input | 1 | 1 = MSB sent first, 0 = LSB sent first |
| front_half | input | 1 | 32-bit slots: 1 = valid bits in first half, 0 = in second half |
| ch1_out | output | 16 | Channel 1 sample, two's complement |
| ch2_out | output | 16 | Channel 2 sample, two's complement |
| frame_valid | output | 1 | One-cycle strobe when both samples are updated |

## Verification
The bench covers all six combinations of slot size, bit order and placement. It fills every bit outside the window with random data, so a window that is off by one position, or that uses the wrong half, shows up as corrupted samples. It includes the extreme values 0x8000, 0x7FFF, 0xFFFF and 0x0001: a design that reverses the bit order or drops the sign bit gives a mirrored or truncated value for these. One run starts in the middle of a channel-1 slot. A design that treats a partial slot as complete would report an extra, misaligned frame there. Between strobes the bench checks that the outputs hold, and that each strobe lasts one cycle.

// File: rtl/pcm_rx_pkg.sv
package pcm_rx_pkg;

  // First valid slot index for the selected framing
  function automatic int unsigned win_start(input logic slot32, input logic front_half,
                                            input int unsigned short_slot,
                                            input int unsigned long_slot,
                                            input int unsigned sample_w);
    if (!slot32)        return short_slot - sample_w;
    else if (front_half) return 0;
    else                return long_slot - sample_w;
  endfunction

endpackage

// File: rtl/pcm_in_sync.sv
module pcm_in_sync #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic bck,
  input  logic lrck,
  input  logic sdat,
  output logic bit_stb,
  output logic bit_val,
  output logic bit_lr
);
  localparam int NSIG = 3;

  logic [NSIG-1:0] stage [SYNC_STAGES];
  logic            bck_d;

  generate
    for (genvar s = 0; s < SYNC_STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) stage[s] <= '0;
          else     stage[s] <= {bck, lrck, sdat};
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) stage[s] <= '0;
          else     stage[s] <= stage[s-1];
        end
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) bck_d <= 1'b0;
    else     bck_d <= stage[SYNC_STAGES-1][2];
  end

  assign bit_stb = stage[SYNC_STAGES-1][2] & ~bck_d;
  assign bit_lr  = stage[SYNC_STAGES-1][1];
  assign bit_val = stage[SYNC_STAGES-1][0];

  // R2: an edge strobe never lasts two cycles
  p_stb_spacing_r2: assert property (@(posedge clk) disable iff (rst)
    bit_stb |=> !bit_stb);

endmodule

// File: rtl/pcm_slot_shift.sv
module pcm_slot_shift
  import pcm_rx_pkg::*;
#(
  parameter int SAMPLE_W   = 16,
  parameter int SHORT_SLOT = 24,
  parameter int LONG_SLOT  = 32
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                bit_stb,
  input  logic                bit_val,
  input  logic                bit_lr,
  input  logic                slot32,
  input  logic                msb_first,
  input  logic                front_half,
  output logic                slot_done,
  output logic                done_lr,
  output logic [SAMPLE_W-1:0] slot_word
);
  localparam int CNT_W = $clog2(2 * LONG_SLOT);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic                started;
  logic                aligned;
  logic                lr_prev;
  logic [CNT_W-1:0]    cnt;
  logic [CNT_W-1:0]    idx;
  logic                new_slot;
  logic                in_win;
  logic [SAMPLE_W-1:0] acc;
  logic [SAMPLE_W-1:0] acc_base;
  logic [SAMPLE_W-1:0] acc_next;
  int unsigned         start_i;

  assign new_slot = started && (bit_lr != lr_prev);

  always_comb begin
    if (new_slot)            idx = '0;
    else if (cnt == CNT_MAX) idx = cnt;
    else                     idx = cnt + 1'b1;
  end

  always_comb begin
    start_i = win_start(slot32, front_half, SHORT_SLOT, LONG_SLOT, SAMPLE_W);
    in_win  = (int'(idx) >= int'(start_i)) && (int'(idx) < int'(start_i) + SAMPLE_W);
  end

  always_comb begin
    acc_base = new_slot ? '0 : acc;
    acc_next = acc_base;
    if (in_win) begin
      if (msb_first) acc_next = {acc_base[SAMPLE_W-2:0], bit_val};
      else           acc_next = {bit_val, acc_base[SAMPLE_W-1:1]};
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      started   <= 1'b0;
      aligned   <= 1'b0;
      lr_prev   <= 1'b0;
      cnt       <= CNT_MAX;
      acc       <= '0;
      slot_done <= 1'b0;
      done_lr   <= 1'b0;
      slot_word <= '0;
    end else begin
      slot_done <= 1'b0;
      if (bit_stb) begin
        started <= 1'b1;
        lr_prev <= bit_lr;
        cnt     <= idx;
        acc     <= acc_next;
        if (new_slot) begin
          aligned   <= 1'b1;
          slot_done <= aligned;
          done_lr   <= lr_prev;
          slot_word <= acc;
        end
      end
    end
  end

  // R9: index returns to zero after a word-clock change
  p_restart_r9: assert property (@(posedge clk) disable iff (rst)
    (bit_stb && started && (bit_lr != lr_prev)) |=> (cnt == '0));

  // R8: no completed slot before a slot start was observed
  p_done_aligned_r8: assert property (@(posedge clk) disable iff (rst)
    slot_done |-> aligned);

endmodule

// File: rtl/pcm_frame_out.sv
module pcm_frame_out #(
  parameter int SAMPLE_W = 16
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                slot_done,
  input  logic                done_lr,
  input  logic [SAMPLE_W-1:0] slot_word,
  output logic [SAMPLE_W-1:0] ch1_out,
  output logic [SAMPLE_W-1:0] ch2_out,
  output logic                frame_valid
);
  logic [SAMPLE_W-1:0] ch1_hold;
  logic                have_ch1;

  always_ff @(posedge clk) begin
    if (rst) begin
      ch1_hold    <= '0;
      have_ch1    <= 1'b0;
      ch1_out     <= '0;
      ch2_out     <= '0;
      frame_valid <= 1'b0;
    end else begin
      frame_valid <= 1'b0;
      if (slot_done) begin
        if (done_lr) begin
          ch1_hold <= slot_word;
          have_ch1 <= 1'b1;
        end else if (have_ch1) begin
          ch1_out     <= ch1_hold;
          ch2_out     <= slot_word;
          frame_valid <= 1'b1;
        end
      end
    end
  end

  // R1: reset clears all outputs
  p_reset_r1: assert property (@(posedge clk)
    rst |=> (frame_valid == 1'b0 && ch1_out == '0 && ch2_out == '0));

  // R7: strobe is one cycle wide
  p_valid_pulse_r7: assert property (@(posedge clk) disable iff (rst)
    frame_valid |=> !frame_valid);

  // R7: outputs hold between strobes
  p_hold_r7: assert property (@(posedge clk) disable iff (rst)
    !frame_valid |-> ($stable(ch1_out) && $stable(ch2_out)));

  // R8: a frame needs a completed channel-1 slot
  p_valid_needs_ch1_r8: assert property (@(posedge clk) disable iff (rst)
    frame_valid |-> have_ch1);

endmodule

// File: rtl/serial_pcm_rx.sv
module serial_pcm_rx #(
  parameter int SAMPLE_W    = 16,
  parameter int SHORT_SLOT  = 24,
  parameter int LONG_SLOT   = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                bck,
  input  logic                lrck,
  input  logic                sdat,
  input  logic                slot32,
  input  logic                msb_first,
  input  logic                front_half,
  output logic [SAMPLE_W-1:0] ch1_out,
  output logic [SAMPLE_W-1:0] ch2_out,
  output logic                frame_valid
);
  logic                bit_stb;
  logic                bit_val;
  logic                bit_lr;
  logic                slot_done;
  logic                done_lr;
  logic [SAMPLE_W-1:0] slot_word;

  pcm_in_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .bck(bck), .lrck(lrck), .sdat(sdat),
    .bit_stb(bit_stb), .bit_val(bit_val), .bit_lr(bit_lr)
  );

  pcm_slot_shift #(
    .SAMPLE_W(SAMPLE_W), .SHORT_SLOT(SHORT_SLOT), .LONG_SLOT(LONG_SLOT)
  ) u_shift (
    .clk(clk), .rst(rst), .bit_stb(bit_stb), .bit_val(bit_val), .bit_lr(bit_lr),
    .slot32(slot32), .msb_first(msb_first), .front_half(front_half),
    .slot_done(slot_done), .done_lr(done_lr), .slot_word(slot_word)
  );

  pcm_frame_out #(.SAMPLE_W(SAMPLE_W)) u_out (
    .clk(clk), .rst(rst), .slot_done(slot_done), .done_lr(done_lr),
    .slot_word(slot_word), .ch1_out(ch1_out), .ch2_out(ch2_out),
    .frame_valid(frame_valid)
  );

endmodule

// File: tb/sim_serial_pcm_rx.sv
module sim_serial_pcm_rx;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bck = 1'b0, lrck = 1'b0, sdat = 1'b0;
  logic        slot32 = 1'b0, msb_first = 1'b1, front_half = 1'b1;
  logic [15:0] ch1_out, ch2_out;
  logic        frame_valid;

  int checks = 0, errors = 0;
  logic [15:0] e1 [0:255];
  logic [15:0] e2 [0:255];
  int wr_idx = 0, rd_idx = 0;
  logic prev_valid = 1'b0;
  bit finished = 0;

  always #4 clk = ~clk;

  serial_pcm_rx u0 (
    .clk(clk), .rst(rst), .bck(bck), .lrck(lrck), .sdat(sdat),
    .slot32(slot32), .msb_first(msb_first), .front_half(front_half),
    .ch1_out(ch1_out), .ch2_out(ch2_out), .frame_valid(frame_valid)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic int win_first(input logic s32, input logic fr);
    if (!s32) return 8;   // R3
    return fr ? 0 : 16;   // R4
  endfunction

  function automatic logic bit_for(input logic [15:0] s, input int k, input logic msb);
    return msb ? s[15-k] : s[k];  // R5
  endfunction

  // Monitor: frame strobe checks (R2, R3, R4, R5, R6, R7)
  always @(negedge clk) begin
    if (!rst) begin
      if (frame_valid) begin
        check(!prev_valid, "R7 one-cycle strobe", 32'(prev_valid), 32'd0);
        if (rd_idx >= wr_idx) begin
          check(1'b0, "R8 unexpected frame", 32'(rd_idx), 32'(wr_idx));
        end else begin
          check(ch1_out == e1[rd_idx], "R2/R3/R4/R5/R6 ch1", 32'(ch1_out), 32'(e1[rd_idx]));
          check(ch2_out == e2[rd_idx], "R2/R3/R4/R5/R6 ch2", 32'(ch2_out), 32'(e2[rd_idx]));
        end
        rd_idx++;
      end
    end
    prev_valid = frame_valid;
  end

  task automatic send_bit(input logic lr, input logic d);
    @(negedge clk);
    bck = 1'b0; lrck = lr; sdat = d;
    repeat (4) @(negedge clk);
    bck = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  task automatic send_slot(input logic lr, input logic [15:0] s);
    int n = slot32 ? 32 : 24;
    int st = win_first(slot32, front_half);
    for (int i = 0; i < n; i++) begin
      if (i >= st && i < st + 16) send_bit(lr, bit_for(s, i - st, msb_first));
      else                        send_bit(lr, 1'($urandom));  // R6 junk
    end
  endtask

  task automatic send_frame(input logic [15:0] a, input logic [15:0] b);
    e1[wr_idx] = a; e2[wr_idx] = b; wr_idx++;
    send_slot(1'b1, a);
    send_slot(1'b0, b);
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1'b1; bck = 1'b0; lrck = 1'b0;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1: reset state
    check(ch1_out == 16'h0 && ch2_out == 16'h0, "R1 outputs zero", {ch1_out, ch2_out}, 32'd0);
    check(frame_valid == 1'b0, "R1 strobe low", 32'(frame_valid), 32'd0);
  endtask

  task automatic finish_group();
    send_bit(1'b1, 1'b0);  // flush: first ch1 bit completes ch2 (R7)
    repeat (12) @(negedge clk);
    check(rd_idx == wr_idx, "R7 frame count", 32'(rd_idx), 32'(wr_idx));
    repeat (40) @(negedge clk);
    if (wr_idx > 0)
      check(ch1_out == e1[wr_idx-1] && ch2_out == e2[wr_idx-1], "R7 hold",
            {ch1_out, ch2_out}, {e1[wr_idx-1], e2[wr_idx-1]});
  endtask

  task automatic run_group(input logic s32, input logic msb, input logic fr, input int nrand);
    slot32 = s32; msb_first = msb; front_half = fr;
    do_reset();
    rd_idx = 0; wr_idx = 0;
    send_bit(1'b0, 1'b0);            // lead-in so the first ch1 slot is aligned
    send_frame(16'h8000, 16'h7FFF);  // directed extremes
    send_frame(16'hFFFF, 16'h0001);
    for (int f = 0; f < nrand; f++) send_frame(16'($urandom), 16'($urandom));
    finish_group();
  endtask

  initial begin
    void'($urandom(32'd4242));
    run_group(1'b0, 1'b1, 1'b1, 4);  // R3 msb first
    run_group(1'b0, 1'b0, 1'b0, 4);  // R3 placement input ignored, lsb first
    run_group(1'b1, 1'b1, 1'b1, 4);  // R4 front half
    run_group(1'b1, 1'b1, 1'b0, 4);  // R4 rear half
    run_group(1'b1, 1'b0, 1'b1, 4);  // R4/R5 lsb first front
    run_group(1'b1, 1'b0, 1'b0, 4);  // R4/R5 lsb first rear

    // R8/R9: start-up in the middle of a channel-1 slot
    slot32 = 1'b1; msb_first = 1'b1; front_half = 1'b0;
    do_reset();
    rd_idx = 0; wr_idx = 0;
    for (int i = 0; i < 10; i++) send_bit(1'b1, 1'($urandom));
    send_slot(1'b0, 16'h1234);  // completes no frame
    repeat (12) @(negedge clk);
    check(rd_idx == 0, "R8 no frame from partial slot", 32'(rd_idx), 32'd0);
    send_frame(16'hA5C3, 16'h5A3C);
    finish_group();

    if (!finished) begin
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule